// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

This block is an eight-pin general-purpose I/O port that software controls through a small register bus. Each pin is configured on its own. It can be an input or an output. It can be driven by the port's own output register or handed over to an alternate peripheral that supplies its own drive value and output enable. When the pin is not driving, it can also request a pull resistor in a chosen direction.

Every pin watches its own synchronized input level for a transition. A per-pin edge selector picks rising or falling transitions. A matching transition sets a sticky flag, which holds until software writes a zero to it. Software may also write a one to raise a flag on purpose. The interrupt request is high while any pin has both its flag and its interrupt enable set.

The register bus is a single-cycle write and read request. A read returns data, together with a valid strobe, one clock after the request. A small bus state machine has two states. In `BUS_IDLE` a read request moves it to `BUS_RESP`. In `BUS_RESP` another read request keeps it there; any other cycle returns it to `BUS_IDLE`. Each pin also has a level tracker with two states, `PIN_LOW` and `PIN_HIGH`. Moving from `PIN_LOW` to `PIN_HIGH` is a rising transition, and the reverse is a falling transition.

Top module: `gpio_port`

## Requirements
- R1: While reset is low, and right after it is released, every register reads 0, `pad_oe` is 0, `irq` is 0 and `bus_rvalid` is 0.
- R2: The register offsets are: 0 flag, 1 interrupt enable, 2 edge select, 3 output value, 4 direction, 5 pin level (read only), 6 pull enable, 7 function select. A write takes effect at the clock edge that samples it. A read sampled at edge k gives `bus_rdata` with `bus_rvalid` high for the cycle after edge k. `bus_rvalid` stays low in any cycle that no read request precedes.
- R3: When a function-select bit is 0, that pin's `pad_oe` equals its direction bit (1 = output) and its `pad_out` equals its output-value bit.
- R4: When a function-select bit is 1, that pin's `pad_out` equals `alt_out` and its `pad_oe` equals `alt_oe`.
- R5: The pin-level register returns `pad_in` through a two-flop synchronizer. A read sampled at the first or second edge after a change returns the old level. A read sampled at the third edge returns the new level.
- R6: `pad_pull_en` is the pull-enable bit on pins whose `pad_oe` is 0. On those pins `pad_pull_up` is the output-value bit (1 = pull up, 0 = pull down). Both are 0 on driving pins.
- R7: With edge select 0, a rising synchronized transition sets the pin's flag by the third clock edge after the change, and a falling transition does not set it.
- R8: With edge select 1, a falling transition sets the flag, and a rising transition does not.
- R9: A flag holds until software writes 0 to its bit. Writing 1 to a flag bit sets it.
- R10: A detected edge in the same cycle as a write of 0 to that flag leaves the flag set.
- R11: `irq` is the OR over pins of flag AND interrupt enable. An enable bit of 0 masks that pin.
- R12: Writes to the pin-level offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 8 | Pin levels from pads |
| pad_out | output | 8 | Value driven onto pins |
| pad_oe | output | 8 | Pin output enable |
| pad_pull_en | output | 8 | Pull resistor enable |
| pad_pull_up | output | 8 | Pull direction, 1 = up |
| alt_out | input | 8 | Alternate-function drive value |
| alt_oe | input | 8 | Alternate-function output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on a flag bit in the same cycle: the hardware set from a detected edge, and a software write that clears it. The bench changes a pin and waits two clock edges. It then issues a write of zero to the flag register, so that the edge sampling that write is the same edge at which the detector reports the transition. The flag is then read back and must still be set. A second clearing write one cycle later must clear it, which shows that the earlier write was overridden and not ignored.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_FLAG  = 3'd0,
        RA_IEN   = 3'd1,
        RA_EDGE  = 3'd2,
        RA_OUT   = 3'd3,
        RA_DIR   = 3'd4,
        RA_LEVEL = 3'd5,
        RA_PULL  = 3'd6,
        RA_FUNC  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_s,
    input  logic func_sel,
    input  logic dir_out,
    input  logic out_val,
    input  logic pull_on,
    input  logic edge_fall,
    input  logic alt_d,
    input  logic alt_en,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic pin_d,
    output logic pin_en,
    output logic pull_en,
    output logic pull_up,
    output logic flag
);

    pin_state_e state_q, state_d;
    logic       hit;
    logic       flag_q;

    // level tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    // level tracker: next state and transition detection
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        unique case (state_q)
            PIN_LOW: begin
                if (level_s) begin
                    state_d = PIN_HIGH;
                    hit     = !edge_fall;
                end
            end
            PIN_HIGH: begin
                if (!level_s) begin
                    state_d = PIN_LOW;
                    hit     = edge_fall;
                end
            end
            default: begin
                state_d = PIN_LOW;
                hit     = 1'b0;
            end
        endcase
    end

    // sticky flag; a detected edge wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_wr) flag_q <= flag_wdata | hit;
        else              flag_q <= flag_q | hit;
    end

    assign flag = flag_q;

    // pad mux
    always_comb begin
        pin_d   = func_sel ? alt_d  : out_val;
        pin_en  = func_sel ? alt_en : dir_out;
        pull_en = pull_on & ~pin_en;
        pull_up = pull_en & out_val;
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    output logic                  bus_rvalid,
    input  logic [WIDTH-1:0]      flag_vec,
    input  logic [WIDTH-1:0]      level_vec,
    output logic                  flag_wr,
    output logic [WIDTH-1:0]      ien_q,
    output logic [WIDTH-1:0]      edge_q,
    output logic [WIDTH-1:0]      out_q,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      pull_q,
    output logic [WIDTH-1:0]      func_q
);

    bus_state_e       state_q, state_d;
    logic             rd_req, wr_req;
    logic [WIDTH-1:0] rd_mux;
    logic [WIDTH-1:0] rdata_q;

    assign rd_req  = bus_sel & ~bus_wr;
    assign wr_req  = bus_sel &  bus_wr;
    assign flag_wr = wr_req && (bus_addr == RA_FLAG);

    // bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // bus next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            edge_q <= '0;
            out_q  <= '0;
            dir_q  <= '0;
            pull_q <= '0;
            func_q <= '0;
        end else if (wr_req) begin
            case (bus_addr)
                RA_IEN:  ien_q  <= bus_wdata;
                RA_EDGE: edge_q <= bus_wdata;
                RA_OUT:  out_q  <= bus_wdata;
                RA_DIR:  dir_q  <= bus_wdata;
                RA_PULL: pull_q <= bus_wdata;
                RA_FUNC: func_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        case (bus_addr)
            RA_FLAG:  rd_mux = flag_vec;
            RA_IEN:   rd_mux = ien_q;
            RA_EDGE:  rd_mux = edge_q;
            RA_OUT:   rd_mux = out_q;
            RA_DIR:   rd_mux = dir_q;
            RA_LEVEL: rd_mux = level_vec;
            RA_PULL:  rd_mux = pull_q;
            RA_FUNC:  rd_mux = func_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    output logic                  bus_rvalid,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_pull_en,
    output logic [WIDTH-1:0]      pad_pull_up,
    input  logic [WIDTH-1:0]      alt_out,
    input  logic [WIDTH-1:0]      alt_oe,
    output logic                  irq
);

    logic [WIDTH-1:0] level_s;
    logic [WIDTH-1:0] flag_vec;
    logic             flag_wr;
    logic [WIDTH-1:0] ien_q, edge_q, out_q, dir_q, pull_q, func_q;

    gpio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (level_s)
    );

    gpio_regbank #(
        .WIDTH (WIDTH)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .flag_vec   (flag_vec),
        .level_vec  (level_s),
        .flag_wr    (flag_wr),
        .ien_q      (ien_q),
        .edge_q     (edge_q),
        .out_q      (out_q),
        .dir_q      (dir_q),
        .pull_q     (pull_q),
        .func_q     (func_q)
    );

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        gpio_pin_cell cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_s    (level_s[p]),
            .func_sel   (func_q[p]),
            .dir_out    (dir_q[p]),
            .out_val    (out_q[p]),
            .pull_on    (pull_q[p]),
            .edge_fall  (edge_q[p]),
            .alt_d      (alt_out[p]),
            .alt_en     (alt_oe[p]),
            .flag_wr    (flag_wr),
            .flag_wdata (bus_wdata[p]),
            .pin_d      (pad_out[p]),
            .pin_en     (pad_oe[p]),
            .pull_en    (pad_pull_en[p]),
            .pull_up    (pad_pull_up[p]),
            .flag       (flag_vec[p])
        );
    end

    assign irq = |(flag_vec & ien_q);

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rvalid,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pull_en,
    input logic [WIDTH-1:0] pad_pull_up,
    input logic             irq
);

    always @(posedge clk) begin
        if (!rst_n) begin
            // R1
            rst_quiet_chk: assert (!irq && pad_oe == '0 && !bus_rvalid);
        end
    end

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_sel && bus_wr)) |=> irq);

    // R6
    pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    // R6
    pull_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & ~pad_pull_en) == '0);

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rvalid  (bus_rvalid),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up),
    .irq         (irq)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;

    localparam int W = 8;
    localparam logic [2:0] A_FLAG = 3'd0, A_IEN = 3'd1, A_EDGE = 3'd2, A_OUT = 3'd3,
                           A_DIR = 3'd4, A_LEVEL = 3'd5, A_PULL = 3'd6, A_FUNC = 3'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         bus_rvalid;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [W-1:0] alt_out = '0;
    logic [W-1:0] alt_oe = '0;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] rd;

    always #4 clk = ~clk;

    gpio_port #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_write(logic [2:0] a, logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        n_checks++;
        if (bus_rvalid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2: rvalid actual %0b expected 1", bus_rvalid);
        end
        d = bus_rdata;
    endtask

    task automatic do_reset();
        pad_in = '0; alt_out = '0; alt_oe = '0;
        bus_sel = 1'b0; bus_wr = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pad_oe", pad_oe, 0);
        check("R1 irq", irq, 0);
        check("R1 rvalid", bus_rvalid, 0);
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), rd);
            check("R1 reg zero", rd, 0);
        end
        @(negedge clk);
        check("R2 rvalid idle", bus_rvalid, 0);
    endtask

    task automatic t_rw();
        do_reset();
        bus_write(A_IEN, 8'h11); bus_write(A_EDGE, 8'h22); bus_write(A_OUT, 8'h33);
        bus_write(A_DIR, 8'h44); bus_write(A_PULL, 8'h55); bus_write(A_FUNC, 8'h66);
        bus_write(A_FLAG, 8'h77);
        bus_read(A_IEN, rd);  check("R2 ien", rd, 8'h11);
        bus_read(A_EDGE, rd); check("R2 edge", rd, 8'h22);
        bus_read(A_OUT, rd);  check("R2 out", rd, 8'h33);
        bus_read(A_DIR, rd);  check("R2 dir", rd, 8'h44);
        bus_read(A_PULL, rd); check("R2 pull", rd, 8'h55);
        bus_read(A_FUNC, rd); check("R2 func", rd, 8'h66);
        bus_read(A_FLAG, rd); check("R9 flag write 1", rd, 8'h77);
    endtask

    task automatic t_modes();
        do_reset();
        bus_write(A_DIR, 8'h3C); bus_write(A_OUT, 8'h5A);
        check("R3 pad_oe", pad_oe, 8'h3C);
        check("R3 pad_out", pad_out, 8'h5A);
        alt_out = 8'hCC; alt_oe = 8'hAA;
        bus_write(A_FUNC, 8'hF0);
        check("R4 pad_out", pad_out, 8'hCA);
        check("R4 pad_oe", pad_oe, 8'hAC);
    endtask

    task automatic t_pull();
        do_reset();
        bus_write(A_DIR, 8'h0F); bus_write(A_PULL, 8'hFF); bus_write(A_OUT, 8'hA5);
        check("R6 pull_en", pad_pull_en, 8'hF0);
        check("R6 pull_up", pad_pull_up, 8'hA0);
    endtask

    task automatic t_level();
        do_reset();
        pad_in = 8'h96;
        bus_read(A_LEVEL, rd); check("R5 edge1 old", rd, 8'h00);
        bus_read(A_LEVEL, rd); check("R5 edge2 old", rd, 8'h00);
        bus_read(A_LEVEL, rd); check("R5 edge3 new", rd, 8'h96);
    endtask

    task automatic t_rise();
        do_reset();
        pad_in = 8'h04;
        repeat (3) @(posedge clk); @(negedge clk);
        bus_read(A_FLAG, rd); check("R7 rising sets", rd, 8'h04);
        bus_write(A_FLAG, 8'h00);
        pad_in = 8'h00;
        settle();
        bus_read(A_FLAG, rd); check("R7 falling ignored", rd, 8'h00);
    endtask

    task automatic t_fall();
        do_reset();
        bus_write(A_EDGE, 8'h10);
        pad_in = 8'h10;
        settle();
        bus_read(A_FLAG, rd); check("R8 rising ignored", rd, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(posedge clk); @(negedge clk);
        bus_read(A_FLAG, rd); check("R8 falling sets", rd, 8'h10);
    endtask

    task automatic t_sticky_irq();
        do_reset();
        bus_write(A_FLAG, 8'h02);
        settle();
        bus_read(A_FLAG, rd); check("R9 flag holds", rd, 8'h02);
        check("R11 masked irq", irq, 0);
        bus_write(A_IEN, 8'h02);
        check("R11 irq on", irq, 1);
        bus_write(A_IEN, 8'hFD);
        check("R11 other enables", irq, 0);
        bus_write(A_IEN, 8'h02);
        bus_write(A_FLAG, 8'h00);
        check("R9 clear drops irq", irq, 0);
        bus_read(A_FLAG, rd); check("R9 cleared", rd, 8'h00);
    endtask

    task automatic t_collide();
        do_reset();
        pad_in = 8'h80;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_write(A_FLAG, 8'h00);
        bus_read(A_FLAG, rd); check("R10 edge beats clear", rd, 8'h80);
        bus_write(A_FLAG, 8'h00);
        bus_read(A_FLAG, rd); check("R10 later clear", rd, 8'h00);
    endtask

    task automatic t_level_ro();
        do_reset();
        bus_write(A_LEVEL, 8'hFF);
        bus_read(A_LEVEL, rd); check("R12 level unchanged", rd, 8'h00);
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), rd);
            check("R12 no register touched", rd, 0);
        end
        check("R12 pad_oe", pad_oe, 0);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_modes();
        t_pull();
        t_level();
        t_rise();
        t_fall();
        t_sticky_irq();
        t_collide();
        t_level_ro();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule